// File: doc/BRIEF.md
# Event timer hub

The hub is the shared top of a multi-channel event timer. It owns a 64-bit main counter that advances on a tick-enable strobe. It also owns the global configuration word, the interrupt status word and the routing of every channel onto a vector of interrupt lines. The comparator channels are separate blocks outside this one. They connect through a register-window port, and they report back their event strobe, their enable, their trigger mode and their routing field.

Software reaches the hub through a 32-bit register bus. A request may also carry a 64-bit write. The hub breaks it into a low-word write followed by a high-word write, and it drops the high half when the low half is refused. Offsets from 0x100 up to 0x3FF are forwarded to the channels in windows of 32 bytes each. Lower offsets select the hub's own registers. These are: capabilities at 0x000, tick period in femtoseconds at 0x004, config low at 0x010, config high at 0x014, status at 0x020 with its upper word at 0x024 reading zero, and counter low and high at 0x0F0 and 0x0F4.

Top module: `evt_timer_hub`

## Requirements
- R1: While config bit 0 (enable) is 1, each cycle with `tick_en` high adds one to the 64-bit counter, which wraps from all ones to zero. Cycles with `tick_en` low leave it unchanged.
- R2: While enable is 0 the counter holds its value and `ch_run` is 0. Setting enable again resumes counting from the held value.
- R3: A write to 0x0F0 replaces only counter bits 31:0, and a write to 0x0F4 replaces only bits 63:32. Both are readable at the same offsets, and a counter write takes priority over a tick in the same cycle.
- R4: While config bit 1 (legacy) is 1, channel 0 is routed to `irq` bit 0 and channel 1 to `irq` bit 8, whatever their routing fields hold. Channels 2 and up keep their own field.
- R5: While legacy is 0, channel i is routed to the `irq` bit given by its field `ch_route[i*RW +: RW]`.
- R6: An event on a channel has no effect on `irq` or on status unless both that channel's `ch_en` bit and global enable are 1.
- R7: An accepted event on a level-mode channel (`ch_level` bit 1) sets status bit i in the next cycle. Its routed line stays high while that bit is set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: An accepted event on an edge-mode channel drives its routed line high for exactly one cycle, one cycle after the event, and leaves status unchanged.
- R9: A 64-bit request must be a write with address bits 2:0 equal to zero, or it is acknowledged with an error and changes nothing. An accepted one writes the low word at the given address, then the high word at address+4. If the low write is refused (`chw_fail`), the high write is not issued and the error flag is returned.
- R10: An address from 0x100 to 0x3FF selects channel (addr-0x100)/32 at byte offset addr[4:0]. A channel index at or above NUM_CH gives no strobe, and a read there returns 0.
- R11: The capabilities word reads bits 7:0 = 0x01, bits 12:8 = NUM_CH-1, bit 13 = 1 (64-bit counter) and bit 15 = 1 (legacy routing), with all other bits 0. The period word reads 10000000 fs, or 69841279 fs when ALT_CLOCK is 1. Any undefined hub offset reads 0.
- R12: Config high (0x014) stores all 32 written bits. Config low keeps only bits 1:0, and its other bits read 0.
- R13: A 32-bit request gets `bus_ack` one cycle after it is sampled, and an accepted 64-bit write gets it two cycles after. A rejected 64-bit request, or one whose low half fails, is acknowledged after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance strobe |
| bus_req | input | 1 | Request strobe, sampled only while idle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_dw | input | 1 | 1 = 64-bit write request |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 64 | Write data; bits 63:32 used only for 64-bit writes |
| bus_ack | output | 1 | Request completed |
| bus_err | output | 1 | Request rejected or refused, valid with ack |
| bus_rdata | output | 32 | Read data, valid with ack |
| chw_wr | output | 1 | Channel window write strobe |
| chw_rd | output | 1 | Channel window read strobe |
| chw_ch | output | 5 | Selected channel |
| chw_off | output | 5 | Byte offset in the window |
| chw_wdata | output | 32 | Channel write data |
| chw_rdata | input | 32 | Channel read data, same cycle |
| chw_fail | input | 1 | Channel refuses the current write |
| ch_evt | input | NUM_CH | Channel event strobes |
| ch_en | input | NUM_CH | Channel interrupt enables |
| ch_level | input | NUM_CH | 1 = level mode, 0 = edge mode |
| ch_route | input | NUM_CH*RW | Routing field per channel |
| counter | output | 64 | Main counter value |
| ch_run | output | 1 | Channels may run (global enable) |
| irq | output | NUM_IRQ | Interrupt lines |

## Verification
A wrong counter state shows up on `counter` at the next clock edge. It shows up as a wrong step, a missing hold, or a lost half after a word write. A stuck or missing status bit shows up as a routed line that stays high or never rises one cycle after the event. It can also be seen in the status read-back. Errors in the request sequencer appear as an acknowledge in the wrong cycle, a missing or extra error flag, or a channel strobe that should have been skipped. They become visible within one or two cycles of the request.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned WIN_IDX_W = 5;

   localparam logic [ADDR_W-1:0] OFS_CAPS    = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_PERIOD  = 12'h004;
   localparam logic [ADDR_W-1:0] OFS_CFG_LO  = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_CFG_HI  = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_STAT_LO = 12'h020;
   localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h0F0;
   localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h0F4;

   // channel windows start at 0x100 (index 8 in 32-byte units)
   localparam logic [WIN_IDX_W-1:0] WIN_FIRST = 5'd8;

   localparam logic [WORD_W-1:0] PERIOD_STD_FS = 32'd10000000;
   localparam logic [WORD_W-1:0] PERIOD_ALT_FS = 32'd69841279;

   typedef struct packed {
      logic              valid;
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [WORD_W-1:0] data;
   } word_op_t;

   typedef enum logic {SP_IDLE, SP_HIGH} split_st_e;

endpackage

// File: rtl/evt_bus_split.sv
module evt_bus_split
   import evt_timer_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_req,
   input  logic                bus_wr,
   input  logic                bus_dw,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [2*WORD_W-1:0] bus_wdata,
   input  logic [WORD_W-1:0]   op_rdata,
   input  logic                op_fail,
   output word_op_t            op,
   output logic                busy,
   output logic                bus_ack,
   output logic                bus_err,
   output logic [WORD_W-1:0]   bus_rdata
);

   split_st_e         st;
   logic [ADDR_W-1:0] hi_addr;
   logic [WORD_W-1:0] hi_data;
   logic              bad;

   // 64-bit requests: writes only, 8-byte aligned; words: 4-byte aligned
   assign bad  = bus_dw ? ((bus_addr[2:0] != 3'b000) || !bus_wr)
                        : (bus_addr[1:0] != 2'b00);
   assign busy = (st == SP_HIGH);

   always_comb begin
      op = '0;
      if (st == SP_HIGH) begin
         op.valid = 1'b1;
         op.wr    = 1'b1;
         op.addr  = hi_addr;
         op.data  = hi_data;
      end else if (bus_req && !bad) begin
         op.valid = 1'b1;
         op.wr    = bus_wr;
         op.addr  = bus_addr;
         op.data  = bus_wdata[WORD_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SP_IDLE;
         hi_addr   <= '0;
         hi_data   <= '0;
         bus_ack   <= 1'b0;
         bus_err   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack <= 1'b0;
         bus_err <= 1'b0;
         if (st == SP_HIGH) begin
            st        <= SP_IDLE;
            bus_ack   <= 1'b1;
            bus_err   <= op_fail;
            bus_rdata <= '0;
         end else if (bus_req) begin
            if (bad) begin
               bus_ack   <= 1'b1;
               bus_err   <= 1'b1;
               bus_rdata <= '0;
            end else if (bus_dw) begin
               if (op_fail) begin
                  bus_ack   <= 1'b1;
                  bus_err   <= 1'b1;
                  bus_rdata <= '0;
               end else begin
                  st      <= SP_HIGH;
                  hi_addr <= {bus_addr[ADDR_W-1:3], 3'b100};
                  hi_data <= bus_wdata[2*WORD_W-1:WORD_W];
               end
            end else begin
               bus_ack   <= 1'b1;
               bus_err   <= op_fail;
               bus_rdata <= bus_wr ? '0 : op_rdata;
            end
         end
      end
   end

endmodule

// File: rtl/evt_glb_regs.sv
module evt_glb_regs
   import evt_timer_pkg::*;
#(
   parameter int unsigned NUM_CH    = 3,
   parameter bit          ALT_CLOCK = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  word_op_t             op,
   input  logic [NUM_CH-1:0]    status_set,
   input  logic [WORD_W-1:0]    chw_rdata,
   input  logic                 chw_fail,
   output logic [WORD_W-1:0]    op_rdata,
   output logic                 op_fail,
   output logic                 chw_wr,
   output logic                 chw_rd,
   output logic [WIN_IDX_W-1:0] chw_ch,
   output logic [4:0]           chw_off,
   output logic [WORD_W-1:0]    chw_wdata,
   output logic                 cfg_en,
   output logic                 cfg_legacy,
   output logic [63:0]          counter,
   output logic [NUM_CH-1:0]    status
);

   localparam logic [WORD_W-1:0] TICK_FS = ALT_CLOCK ? PERIOD_ALT_FS : PERIOD_STD_FS;
   localparam logic [4:0]        CH_TOP  = 5'(NUM_CH - 1);
   localparam logic [WORD_W-1:0] CAPS_WORD = {16'h0000, 1'b1, 1'b0, 1'b1, CH_TOP, 8'h01};

   logic              in_win, win_ok, wr_op;
   logic [WORD_W-1:0] cfg_hi;
   logic [NUM_CH-1:0] w1c;

   // window decode: 0x100..0x3FF -> channel (addr[9:5]-8), offset addr[4:0]
   assign in_win    = (op.addr[11:10] == 2'b00) && (op.addr[9:8] != 2'b00);
   assign chw_ch    = op.addr[9:5] - WIN_FIRST;
   assign chw_off   = op.addr[4:0];
   assign win_ok    = in_win && (32'(chw_ch) < NUM_CH);
   assign chw_wr    = op.valid && op.wr && win_ok;
   assign chw_rd    = op.valid && !op.wr && win_ok;
   assign chw_wdata = op.data;
   assign op_fail   = chw_wr && chw_fail;
   assign wr_op     = op.valid && op.wr;

   always_comb begin
      op_rdata = '0;
      if (win_ok) begin
         op_rdata = chw_rdata;
      end else begin
         case (op.addr)
            OFS_CAPS:    op_rdata = CAPS_WORD;
            OFS_PERIOD:  op_rdata = TICK_FS;
            OFS_CFG_LO:  op_rdata = {30'b0, cfg_legacy, cfg_en};
            OFS_CFG_HI:  op_rdata = cfg_hi;
            OFS_STAT_LO: op_rdata = WORD_W'(status);
            OFS_CNT_LO:  op_rdata = counter[31:0];
            OFS_CNT_HI:  op_rdata = counter[63:32];
            default:     op_rdata = '0;
         endcase
      end
   end

   assign w1c = (wr_op && op.addr == OFS_STAT_LO) ? op.data[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en     <= 1'b0;
         cfg_legacy <= 1'b0;
         cfg_hi     <= '0;
         status     <= '0;
         counter    <= '0;
      end else begin
         if (wr_op && op.addr == OFS_CFG_LO) begin
            cfg_en     <= op.data[0];
            cfg_legacy <= op.data[1];
         end
         if (wr_op && op.addr == OFS_CFG_HI)
            cfg_hi <= op.data;
         // a new event wins over a clear in the same cycle
         status <= (status & ~w1c) | status_set;
         if (wr_op && op.addr == OFS_CNT_LO)
            counter <= {counter[63:32], op.data};
         else if (wr_op && op.addr == OFS_CNT_HI)
            counter <= {op.data, counter[31:0]};
         else if (cfg_en && tick_en)
            counter <= counter + 64'd1;
      end
   end

endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
   parameter int unsigned NUM_CH  = 3,
   parameter int unsigned NUM_IRQ = 32,
   parameter int unsigned RW      = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 glb_en,
   input  logic                 legacy,
   input  logic [NUM_CH-1:0]    ch_evt,
   input  logic [NUM_CH-1:0]    ch_en,
   input  logic [NUM_CH-1:0]    ch_level,
   input  logic [NUM_CH*RW-1:0] ch_route,
   input  logic [NUM_CH-1:0]    status,
   output logic [NUM_CH-1:0]    status_set,
   output logic [NUM_IRQ-1:0]   irq
);

   logic [RW-1:0]      line_a [NUM_CH];
   logic [NUM_CH-1:0]  fire;
   logic [NUM_IRQ-1:0] edge_nxt, edge_q, lvl;

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      if (gi == 0) begin : g_leg0
         assign line_a[gi] = legacy ? RW'(0) : ch_route[gi*RW +: RW];
      end else if (gi == 1) begin : g_leg1
         assign line_a[gi] = legacy ? RW'(8) : ch_route[gi*RW +: RW];
      end else begin : g_plain
         assign line_a[gi] = ch_route[gi*RW +: RW];
      end
      assign fire[gi]       = ch_evt[gi] && ch_en[gi] && glb_en;
      assign status_set[gi] = fire[gi] && ch_level[gi];
   end

   always_comb begin
      edge_nxt = '0;
      lvl      = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (fire[i] && !ch_level[i]) edge_nxt[line_a[i]] = 1'b1;
         if (status[i] && ch_level[i]) lvl[line_a[i]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_q <= '0;
      else        edge_q <= edge_nxt;
   end

   assign irq = edge_q | lvl;

endmodule

// File: rtl/evt_timer_hub.sv
module evt_timer_hub
   import evt_timer_pkg::*;
#(
   parameter int unsigned NUM_CH    = 3,
   parameter int unsigned NUM_IRQ   = 32,
   parameter bit          ALT_CLOCK = 1'b0,
   localparam int unsigned RW       = $clog2(NUM_IRQ)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 bus_req,
   input  logic                 bus_wr,
   input  logic                 bus_dw,
   input  logic [11:0]          bus_addr,
   input  logic [63:0]          bus_wdata,
   output logic                 bus_ack,
   output logic                 bus_err,
   output logic [31:0]          bus_rdata,
   output logic                 chw_wr,
   output logic                 chw_rd,
   output logic [4:0]           chw_ch,
   output logic [4:0]           chw_off,
   output logic [31:0]          chw_wdata,
   input  logic [31:0]          chw_rdata,
   input  logic                 chw_fail,
   input  logic [NUM_CH-1:0]    ch_evt,
   input  logic [NUM_CH-1:0]    ch_en,
   input  logic [NUM_CH-1:0]    ch_level,
   input  logic [NUM_CH*RW-1:0] ch_route,
   output logic [63:0]          counter,
   output logic                 ch_run,
   output logic [NUM_IRQ-1:0]   irq
);

   if (NUM_CH < 2 || NUM_CH > 24) begin : g_bad_ch
      $error("evt_timer_hub: NUM_CH must be 2..24");
   end
   if (NUM_IRQ < 16 || (NUM_IRQ & (NUM_IRQ - 1)) != 0) begin : g_bad_irq
      $error("evt_timer_hub: NUM_IRQ must be a power of two >= 16");
   end

   word_op_t          op;
   logic              busy, op_fail, cfg_en, cfg_legacy;
   logic [31:0]       op_rdata;
   logic [NUM_CH-1:0] status, status_set;
   logic              op_valid, op_wr;
   logic [11:0]       op_addr;

   assign op_valid = op.valid;
   assign op_wr    = op.wr;
   assign op_addr  = op.addr;
   assign ch_run   = cfg_en;

   evt_bus_split u_split (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_dw(bus_dw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .op_rdata(op_rdata), .op_fail(op_fail), .op(op), .busy(busy),
      .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
   );

   evt_glb_regs #(.NUM_CH(NUM_CH), .ALT_CLOCK(ALT_CLOCK)) u_regs (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .op(op),
      .status_set(status_set), .chw_rdata(chw_rdata), .chw_fail(chw_fail),
      .op_rdata(op_rdata), .op_fail(op_fail), .chw_wr(chw_wr), .chw_rd(chw_rd),
      .chw_ch(chw_ch), .chw_off(chw_off), .chw_wdata(chw_wdata),
      .cfg_en(cfg_en), .cfg_legacy(cfg_legacy), .counter(counter), .status(status)
   );

   evt_irq_route #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .RW(RW)) u_irq (
      .clk(clk), .rst_n(rst_n), .glb_en(cfg_en), .legacy(cfg_legacy),
      .ch_evt(ch_evt), .ch_en(ch_en), .ch_level(ch_level), .ch_route(ch_route),
      .status(status), .status_set(status_set), .irq(irq)
   );

endmodule

// File: rtl/evt_timer_hub_chk.sv
module evt_timer_hub_chk #(
   parameter int unsigned NUM_CH  = 3,
   parameter int unsigned NUM_IRQ = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_en,
   input logic [63:0]        counter,
   input logic               ch_run,
   input logic               cfg_legacy,
   input logic [NUM_CH-1:0]  ch_evt,
   input logic [NUM_CH-1:0]  ch_en,
   input logic [NUM_CH-1:0]  ch_level,
   input logic [NUM_IRQ-1:0] irq,
   input logic [NUM_CH-1:0]  status,
   input logic               bus_req,
   input logic               bus_wr,
   input logic               bus_dw,
   input logic [11:0]        bus_addr,
   input logic               busy,
   input logic               bus_ack,
   input logic               bus_err,
   input logic               chw_wr,
   input logic               chw_fail,
   input logic               op_valid,
   input logic               op_wr,
   input logic [11:0]        op_addr
);

   logic cnt_wr;
   assign cnt_wr = op_valid && op_wr && (op_addr == 12'h0F0 || op_addr == 12'h0F4);

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run && tick_en && !cnt_wr) |=> counter == $past(counter) + 64'd1);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_run && !cnt_wr) |=> counter == $past(counter));

   a_r4_legacy0: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run && cfg_legacy && ch_evt[0] && ch_en[0] && !ch_level[0]) |=> irq[0]);

   a_r4_legacy1: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run && cfg_legacy && ch_evt[1] && ch_en[1] && !ch_level[1]) |=> irq[8]);

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_st
      a_r7_status_src: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status[gi]) |-> $past(ch_evt[gi] && ch_en[gi] && ch_level[gi] && ch_run));
   end

   a_r9_misalign: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_req && bus_dw && bus_addr[2:0] != 3'b000) |=> (bus_ack && bus_err));

   a_r9_skip_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_req && bus_dw && bus_wr && bus_addr[2:0] == 3'b000 && chw_wr && chw_fail)
      |=> (!chw_wr && bus_ack && bus_err));

   a_r13_word_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_req && !bus_dw) |=> bus_ack);

endmodule

bind evt_timer_hub evt_timer_hub_chk #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .counter(counter), .ch_run(ch_run),
   .cfg_legacy(cfg_legacy), .ch_evt(ch_evt), .ch_en(ch_en), .ch_level(ch_level),
   .irq(irq), .status(status), .bus_req(bus_req), .bus_wr(bus_wr), .bus_dw(bus_dw),
   .bus_addr(bus_addr), .busy(busy), .bus_ack(bus_ack), .bus_err(bus_err),
   .chw_wr(chw_wr), .chw_fail(chw_fail), .op_valid(op_valid), .op_wr(op_wr),
   .op_addr(op_addr)
);

// File: tb/test_evt_timer_hub.sv
`timescale 1ns/1ps
module test_evt_timer_hub;

   localparam int NCH = 3;
   localparam int NIRQ = 32;
   localparam int RWB = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic bus_req = 1'b0, bus_wr = 1'b0, bus_dw = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic bus_ack, bus_err;
   logic [31:0] bus_rdata;
   logic chw_wr, chw_rd, chw_fail;
   logic [4:0] chw_ch, chw_off;
   logic [31:0] chw_wdata, chw_rdata;
   logic [NCH-1:0] ch_evt = '0, ch_en = '1, ch_level = '0;
   logic [NCH*RWB-1:0] ch_route = {5'd5, 5'd7, 5'd7};
   logic [63:0] counter;
   logic ch_run;
   logic [NIRQ-1:0] irq;

   always #2 clk = ~clk;

   // channel stub
   assign chw_rdata = {16'hC0DE, 3'b000, chw_ch, 3'b000, chw_off};
   assign chw_fail  = chw_wr && (chw_off == 5'd0) && (chw_wdata == 32'hBAD0_BAD0);

   evt_timer_hub #(.NUM_CH(NCH), .NUM_IRQ(NIRQ)) i_evt_timer_hub (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_dw(bus_dw), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_err(bus_err), .bus_rdata(bus_rdata), .chw_wr(chw_wr), .chw_rd(chw_rd),
      .chw_ch(chw_ch), .chw_off(chw_off), .chw_wdata(chw_wdata), .chw_rdata(chw_rdata),
      .chw_fail(chw_fail), .ch_evt(ch_evt), .ch_en(ch_en), .ch_level(ch_level),
      .ch_route(ch_route), .counter(counter), .ch_run(ch_run), .irq(irq)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // scoreboard queues
   string       q_tag[$];
   logic        q_err[$];
   logic        q_chk[$];
   logic [31:0] q_dat[$];

   // channel strobe log
   logic [41:0] wr_log[$];
   int          rd_strobes = 0;
   always @(posedge clk) begin
      if (chw_wr) wr_log.push_back({chw_ch, chw_off, chw_wdata});
      if (chw_rd) rd_strobes++;
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && bus_ack) begin
         if (q_tag.size() == 0) begin
            check("R13 unexpected ack", 64'd1, 64'd0);
         end else begin
            string t;
            logic  e, c;
            logic [31:0] d;
            t = q_tag.pop_front();
            e = q_err.pop_front();
            c = q_chk.pop_front();
            d = q_dat.pop_front();
            check({t, " err"}, 64'(bus_err), 64'(e));
            if (c) check({t, " data"}, 64'(bus_rdata), 64'(d));
         end
      end
   end

   task automatic bus_op(bit wr, bit dw, logic [11:0] addr, logic [63:0] wd,
                         bit chkd, logic [31:0] expd, bit experr, int explat, string tag);
      int n;
      q_tag.push_back(tag);
      q_err.push_back(experr);
      q_chk.push_back(chkd);
      q_dat.push_back(expd);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = wr; bus_dw = dw; bus_addr = addr; bus_wdata = wd;
      n = 0;
      while (n < 8) begin
         @(negedge clk);
         n++;
         bus_req = 1'b0;
         if (bus_ack) break;
      end
      check({tag, " R13 latency"}, 64'(n), 64'(explat));
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
      bus_op(1'b0, 1'b0, a, 64'd0, 1'b1, e, 1'b0, 1, tag);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
      bus_op(1'b1, 1'b0, a, {32'd0, d}, 1'b0, 32'd0, 1'b0, 1, tag);
   endtask

   task automatic ticks(int n);
      repeat (n) begin @(negedge clk); tick_en = 1'b1; end
      @(negedge clk); tick_en = 1'b0;
   endtask

   // drive one-cycle events; check irq one cycle later and again after that
   task automatic fire(logic [NCH-1:0] m, logic [31:0] exp1, logic [31:0] exp2, string tag);
      @(negedge clk); ch_evt = m;
      @(negedge clk); ch_evt = '0;
      check({tag, " irq"}, 64'(irq), 64'(exp1));
      @(negedge clk);
      check({tag, " irq next"}, 64'(irq), 64'(exp2));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // reset state
      check("reset counter", counter, 64'd0);
      check("reset irq", 64'(irq), 64'd0);
      check("R2 reset ch_run", 64'(ch_run), 64'd0);
      check("R13 reset ack", 64'(bus_ack), 64'd0);
      rst_n = 1'b1;

      // R11 capabilities, period, undefined
      rd(12'h000, 32'h0000_A201, "R11 caps");
      rd(12'h004, 32'd10000000, "R11 period");
      rd(12'h030, 32'd0, "R11 undefined 0x030");
      rd(12'h0FC, 32'd0, "R11 undefined 0x0FC");

      // R12 config storage
      wr(12'h014, 32'hFFFF_FFFF, "R12 cfg hi wr");
      rd(12'h014, 32'hFFFF_FFFF, "R12 cfg hi rd");
      wr(12'h010, 32'hFFFF_FFFC, "R12 cfg lo wr");
      rd(12'h010, 32'd0, "R12 cfg lo rd");

      // R3 counter halves
      wr(12'h0F0, 32'hFFFF_FFFE, "R3 cnt lo");
      wr(12'h0F4, 32'hFFFF_FFFF, "R3 cnt hi");
      check("R3 counter port", counter, 64'hFFFF_FFFF_FFFF_FFFE);
      rd(12'h0F4, 32'hFFFF_FFFF, "R3 cnt hi rd");

      // R1 count with wrap
      wr(12'h010, 32'd1, "R1 enable");
      check("R2 ch_run on", 64'(ch_run), 64'd1);
      repeat (5) @(negedge clk);
      check("R1 no tick no step", counter, 64'hFFFF_FFFF_FFFF_FFFE);
      ticks(3);
      check("R1 wrap", counter, 64'd1);

      // R2 hold and resume
      wr(12'h010, 32'd0, "R2 disable");
      check("R2 ch_run off", 64'(ch_run), 64'd0);
      ticks(4);
      check("R2 held", counter, 64'd1);
      wr(12'h010, 32'd1, "R2 re-enable");
      ticks(2);
      check("R2 resumed", counter, 64'd3);
      rd(12'h0F0, 32'd3, "R2 cnt lo rd");
      wr(12'h010, 32'd0, "R2 disable again");

      // R3 each half keeps the other
      wr(12'h0F4, 32'h0000_0012, "R3 hi only");
      wr(12'h0F0, 32'h0000_0034, "R3 lo only");
      check("R3 merged", counter, 64'h0000_0012_0000_0034);

      // R9 64-bit writes
      bus_op(1'b1, 1'b1, 12'h0F0, 64'h0000_0005_0000_0007, 1'b0, 0, 1'b0, 2, "R9 dw cnt");
      check("R9 dw counter", counter, 64'h0000_0005_0000_0007);
      bus_op(1'b1, 1'b1, 12'h0F4, 64'hAAAA_AAAA_BBBB_BBBB, 1'b0, 0, 1'b1, 1, "R9 misaligned");
      check("R9 misaligned no change", counter, 64'h0000_0005_0000_0007);
      bus_op(1'b0, 1'b1, 12'h0F0, 64'd0, 1'b0, 0, 1'b1, 1, "R9 dw read rejected");

      // R10 windows and R9 ordering / skip
      wr_log.delete();
      bus_op(1'b1, 1'b1, 12'h120, 64'h0000_2222_0000_1111, 1'b0, 0, 1'b0, 2, "R10 dw ch1");
      check("R9 two strobes", 64'(wr_log.size()), 64'd2);
      if (wr_log.size() == 2) begin
         check("R9 low first", 64'(wr_log[0]), 64'({5'd1, 5'd0, 32'h1111}));
         check("R9 high second", 64'(wr_log[1]), 64'({5'd1, 5'd4, 32'h2222}));
      end
      wr_log.delete();
      bus_op(1'b1, 1'b1, 12'h140, 64'h0000_3333_BAD0_BAD0, 1'b0, 0, 1'b1, 1, "R9 low refused");
      check("R9 high skipped", 64'(wr_log.size()), 64'd1);
      rd(12'h15C, 32'hC0DE_021C, "R10 ch2 off1c");
      rd_strobes = 0;
      rd(12'h16C, 32'd0, "R10 out of range read");
      check("R10 no strobe", 64'(rd_strobes), 64'd0);
      wr_log.delete();
      wr(12'h160, 32'h55, "R10 out of range write");
      check("R10 no write strobe", 64'(wr_log.size()), 64'd0);

      // routing, edge mode
      wr(12'h010, 32'd1, "R5 enable");
      fire(3'b100, 32'h0000_0020, 32'd0, "R5 ch2 route5");
      fire(3'b111, 32'h0000_00A0, 32'd0, "R5 all routed");
      rd(12'h020, 32'd0, "R8 edge no status");
      wr(12'h010, 32'd3, "R4 legacy on");
      rd(12'h010, 32'd3, "R12 cfg lo bits");
      fire(3'b111, 32'h0000_0121, 32'd0, "R4 legacy");
      fire(3'b010, 32'h0000_0100, 32'd0, "R8 ch1 single pulse");

      // gating
      ch_en = 3'b011;
      fire(3'b100, 32'd0, 32'd0, "R6 channel disabled");
      ch_en = 3'b111;
      wr(12'h010, 32'd0, "R6 global off");
      fire(3'b111, 32'd0, 32'd0, "R6 global disabled");
      rd(12'h020, 32'd0, "R6 no status");

      // level mode
      wr(12'h010, 32'd1, "R7 enable");
      ch_level = 3'b010;
      ch_route[9:5] = 5'd3;
      fire(3'b010, 32'h0000_0008, 32'h0000_0008, "R7 level held");
      rd(12'h020, 32'h0000_0002, "R7 status set");
      wr(12'h020, 32'd0, "R7 write zero");
      rd(12'h020, 32'h0000_0002, "R7 zero keeps");
      check("R7 line still high", 64'(irq), 64'h8);
      wr(12'h020, 32'h0000_0002, "R7 w1c");
      check("R7 line dropped", 64'(irq), 64'd0);
      rd(12'h020, 32'd0, "R7 status cleared");

      repeat (3) @(negedge clk);
      check("R13 all acks seen", 64'(q_tag.size()), 64'd0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule